// File: doc/BRIEF.md
# Banked-Window GPIO Controller with Edge Interrupts

This block controls 48 general-purpose lines, grouped as six 8-bit ports, over a small synchronous byte bus. The bus has a 4-bit offset, 8-bit write and read data, and one write strobe and one read strobe. A one in a port data byte drives that line through a weak pull. A zero releases the line so it can act as an input. Reading a port returns the line levels after a two-stage synchronizer.

The lines of the three lowest ports can raise interrupts. For each of these 24 lines the block keeps a polarity bit, an enable bit and a pending bit. Three addresses form a shared window onto these bits, and a two-bit page field in a separate control byte picks which set the window shows. An enabled line latches its selected edge into its pending bit. The single request output stays high while any pending bit is set. Software finds the source by reading the pending page or the per-port summary byte. It then clears the source by writing ones to the pending page.

Top module: `banked_gpio`

## Requirements
- R1: After reset all line drives are 0, `irq` is 0, and the page field, every polarity bit, every enable bit and every pending bit are 0.
- R2: A write to offset 0x0–0x5 loads that port's byte into `line_drive` (port n is bits 8n+7:8n; a 1 drives the line, a 0 releases it). A write to offset 0x6 changes nothing.
- R3: A read of offset 0x0–0x5 returns the synchronized pad levels of that port. `bus_rdata` updates on the clock edge that samples `bus_rd` and otherwise holds.
- R4: Offset 0x7 holds the page field in bits 7:6. It reads back with bits 5:0 equal to 0.
- R5: Offsets 0x8, 0x9 and 0xA map to ports 0, 1 and 2. Page 1 shows polarity, page 2 shows enable and page 3 shows pending. The three banks are separate storage. While page 0 is selected, window writes have no effect and window reads return 0x00.
- R6: A line in ports 0–2 sets its pending bit when its enable bit is 1 and its synchronized level shows the selected edge (polarity 1 means rising, 0 means falling). The pending bit becomes visible three clock edges after the pad changes. A disabled line never sets its bit.
- R7: On page 3, writing a 1 to a window bit clears that pending bit and writing a 0 leaves it unchanged. If a new edge arrives on the same clock edge as the clear, the bit stays set.
- R8: `irq` is 1 exactly while at least one pending bit is 1.
- R9: Offset 0x6 reads back a summary in which bit n (n = 0..2) is 1 when port n has any pending bit. The other bits read 0.
- R10: Lines 24–47 never set pending state. Reads of offsets 0xB–0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Line levels seen at the pads |
| line_drive | output | 48 | Per-line weak-pull drive enables |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is a new edge on a line arriving on the same clock edge as a software clear of that line's pending bit. Here the edge must win. The bench reaches it by counting the synchronizer and edge-detect stages. It changes the pad on a falling clock edge and waits one cycle. It then starts the clearing write so that the write is sampled on the third rising edge, the same edge on which the pending bit is set. The bench also keeps each edge polarity, a disabled line and the upper ports apart, so that a pending bit set on the wrong edge shows up in the window and summary reads.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;
   // Window page selected by the control byte
   typedef enum logic [1:0] {
      PG_OFF  = 2'd0,
      PG_POL  = 2'd1,
      PG_ENA  = 2'd2,
      PG_PEND = 2'd3
   } page_e;
endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bgpio_irq_port.sv
module bgpio_irq_port #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic             pol_we,
   input  logic             ena_we,
   input  logic             ack_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] pol_q,
   output logic [WIDTH-1:0] ena_q,
   output logic [WIDTH-1:0] pend_q
);
   logic [WIDTH-1:0] level_d;
   logic [WIDTH-1:0] rise, fall, hit, clr;

   assign rise = level & ~level_d;
   assign fall = ~level & level_d;
   assign hit  = ena_q & ((pol_q & rise) | (~pol_q & fall));
   assign clr  = ack_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_d <= '0;
         pol_q   <= '0;
         ena_q   <= '0;
         pend_q  <= '0;
      end else begin
         level_d <= level;
         if (pol_we) pol_q <= wdata;
         if (ena_we) ena_q <= wdata;
         // a fresh edge outranks a simultaneous clear
         pend_q <= (pend_q & ~clr) | hit;
      end
   end
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
   import banked_gpio_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int NUM_PORTS   = 6,
   parameter int IRQ_PORTS   = 3,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [PORT_W-1:0]             bus_wdata,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   output logic [PORT_W-1:0]             bus_rdata,
   input  logic [PORT_W*NUM_PORTS-1:0]   pad_in,
   output logic [PORT_W*NUM_PORTS-1:0]   line_drive,
   output logic                          irq
);
   localparam int NUM_LINES = PORT_W * NUM_PORTS;
   localparam int IRQ_LINES = PORT_W * IRQ_PORTS;
   localparam int PAGE_LSB  = PORT_W - 2;
   localparam logic [ADDR_W-1:0] SUM_ADDR  = ADDR_W'(NUM_PORTS);
   localparam logic [ADDR_W-1:0] PAGE_ADDR = ADDR_W'(NUM_PORTS + 1);
   localparam int WIN_BASE = NUM_PORTS + 2;

   if (IRQ_PORTS > NUM_PORTS) begin : g_bad_irq_ports
      $error("IRQ_PORTS exceeds NUM_PORTS");
   end
   if (IRQ_PORTS > PORT_W) begin : g_bad_summary
      $error("summary byte too narrow for IRQ_PORTS");
   end
   if (WIN_BASE + IRQ_PORTS > (1 << ADDR_W)) begin : g_bad_addr
      $error("address space too small for register map");
   end
   if (PORT_W < 2) begin : g_bad_width
      $error("PORT_W must hold the page field");
   end

   page_e             page_q;
   logic [PORT_W-1:0] pad_port  [NUM_PORTS];
   logic [PORT_W-1:0] pol_port  [IRQ_PORTS];
   logic [PORT_W-1:0] ena_port  [IRQ_PORTS];
   logic [PORT_W-1:0] pend_port [IRQ_PORTS];
   logic [IRQ_LINES-1:0] pend_all;
   logic [IRQ_LINES-1:0] ena_all;
   logic [PORT_W*NUM_PORTS-1:0] pad_sync;
   logic [PORT_W-1:0] summary;
   logic [PORT_W-1:0] rd_val;

   bgpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   // Port data registers: drive enables, readback from pads
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] drive_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  drive_q <= '0;
         else if (bus_wr && bus_addr == ADDR_W'(p))   drive_q <= bus_wdata;
      end
      assign line_drive[p*PORT_W +: PORT_W] = drive_q;
      assign pad_port[p] = pad_sync[p*PORT_W +: PORT_W];
   end

   // Page control byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              page_q <= PG_OFF;
      else if (bus_wr && bus_addr == PAGE_ADDR) page_q <= page_e'(bus_wdata[PORT_W-1:PAGE_LSB]);
   end

   // Interrupt-capable ports behind the banked window
   for (genvar k = 0; k < IRQ_PORTS; k++) begin : g_irq
      logic win_wr;
      assign win_wr = bus_wr && (bus_addr == ADDR_W'(WIN_BASE + k));
      bgpio_irq_port #(.WIDTH(PORT_W)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .level  (pad_port[k]),
         .pol_we (win_wr && page_q == PG_POL),
         .ena_we (win_wr && page_q == PG_ENA),
         .ack_we (win_wr && page_q == PG_PEND),
         .wdata  (bus_wdata),
         .pol_q  (pol_port[k]),
         .ena_q  (ena_port[k]),
         .pend_q (pend_port[k])
      );
      assign pend_all[k*PORT_W +: PORT_W] = pend_port[k];
      assign ena_all[k*PORT_W +: PORT_W]  = ena_port[k];
   end

   always_comb begin
      summary = '0;
      for (int k = 0; k < IRQ_PORTS; k++) summary[k] = |pend_port[k];
   end

   assign irq = |pend_all;

   // Read multiplexer
   always_comb begin
      rd_val = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (bus_addr == ADDR_W'(p)) rd_val = pad_port[p];
      end
      if (bus_addr == SUM_ADDR)  rd_val = summary;
      if (bus_addr == PAGE_ADDR) rd_val = {page_q, {PAGE_LSB{1'b0}}};
      for (int k = 0; k < IRQ_PORTS; k++) begin
         if (bus_addr == ADDR_W'(WIN_BASE + k)) begin
            unique case (page_q)
               PG_POL:  rd_val = pol_port[k];
               PG_ENA:  rd_val = ena_port[k];
               PG_PEND: rd_val = pend_port[k];
               default: rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 6,
   parameter int IRQ_PORTS = 3,
   parameter int ADDR_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [PORT_W-1:0]           bus_wdata,
   input logic                        bus_wr,
   input logic                        bus_rd,
   input logic [PORT_W-1:0]           bus_rdata,
   input logic [PORT_W*NUM_PORTS-1:0] line_drive,
   input logic                        irq,
   input logic [1:0]                  page,
   input logic [PORT_W*IRQ_PORTS-1:0] pend_all,
   input logic [PORT_W*IRQ_PORTS-1:0] ena_all
);
   localparam int NUM_LINES = PORT_W * NUM_PORTS;
   localparam int WIN_BASE  = NUM_PORTS + 2;
   localparam int WIN_LAST  = WIN_BASE + IRQ_PORTS - 1;

   function automatic logic [PORT_W-1:0] pick(logic [NUM_LINES-1:0] v, logic [ADDR_W-1:0] a);
      logic [PORT_W-1:0] r;
      r = '0;
      for (int p = 0; p < NUM_PORTS; p++) if (int'(a) == p) r = v[p*PORT_W +: PORT_W];
      return r;
   endfunction

   logic in_win;
   assign in_win = int'(bus_addr) >= WIN_BASE && int'(bus_addr) <= WIN_LAST;

   p_drive_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && int'(bus_addr) < NUM_PORTS) |->
         pick(line_drive, $past(bus_addr)) == $past(bus_wdata));

   p_page_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rd && int'(bus_addr) == NUM_PORTS + 1) |-> bus_rdata[PORT_W-3:0] == '0);

   p_page_off_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rd && in_win && page == 2'd0) |-> bus_rdata == '0);

   p_set_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_all & ~$past(pend_all) & ~$past(ena_all)) == '0);

   p_clear_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pend_all) & ~pend_all) != '0)) |-> $past(bus_wr && in_win && page == 2'd3));

   p_irq_tracks_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_wr && in_win && page == 2'd3));
endmodule

bind banked_gpio banked_gpio_chk #(
   .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .line_drive(line_drive), .irq(irq), .page(page_q),
   .pend_all(pend_all), .ena_all(ena_all)
);

// File: tb/banked_gpio_tb.sv
module banked_gpio_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [47:0] pad_in = 48'h123456789ABC;
   logic [47:0] line_drive;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   banked_gpio u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .line_drive(line_drive), .irq(irq)
   );

   // {is_read, offset, data-or-expected}; pads held at 48'h123456789ABC
   localparam int NVEC = 31;
   localparam logic [12:0] VECS [NVEC] = '{
      {1'b1, 4'h7, 8'h00}, {1'b1, 4'h8, 8'h00}, {1'b0, 4'h8, 8'hFF},
      {1'b0, 4'h7, 8'hBF}, {1'b1, 4'h7, 8'h80}, {1'b1, 4'h8, 8'h00},
      {1'b0, 4'h9, 8'h5A}, {1'b1, 4'h9, 8'h5A}, {1'b0, 4'h7, 8'h40},
      {1'b1, 4'h9, 8'h00}, {1'b0, 4'hA, 8'hC3}, {1'b1, 4'hA, 8'hC3},
      {1'b0, 4'h7, 8'h80}, {1'b1, 4'h9, 8'h5A}, {1'b1, 4'hA, 8'h00},
      {1'b1, 4'h0, 8'hBC}, {1'b1, 4'h5, 8'h12}, {1'b1, 4'h2, 8'h78},
      {1'b1, 4'hD, 8'h00}, {1'b1, 4'hF, 8'h00}, {1'b1, 4'h6, 8'h00},
      {1'b0, 4'h7, 8'h00}, {1'b0, 4'h9, 8'hFF}, {1'b1, 4'h9, 8'h00},
      {1'b0, 4'h7, 8'h80}, {1'b1, 4'h9, 8'h5A}, {1'b0, 4'h9, 8'h00},
      {1'b0, 4'h7, 8'h40}, {1'b0, 4'hA, 8'h00}, {1'b1, 4'hA, 8'h00},
      {1'b0, 4'h7, 8'h00}
   };

   task automatic check(string req, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rv;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 drive after reset", line_drive, 48'h0);
      check("R1 irq after reset", {47'h0, irq}, 48'h0);
      settle();

      // Register-map table: R3, R4, R5, R9, R10
      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i][12]) begin
            bus_read(VECS[i][11:8], rv);
            checks++;
            if (rv !== VECS[i][7:0]) begin
               errors++;
               $display("FAIL table row %0d (R3 R4 R5 R9 R10): actual %0h expected %0h",
                        i, rv, VECS[i][7:0]);
            end
         end else begin
            bus_write(VECS[i][11:8], VECS[i][7:0]);
         end
      end

      // R2: data write drives the port, summary offset ignores writes
      bus_write(4'h3, 8'hF0);
      check("R2 port 3 drive", line_drive, 48'h0000_F000_0000);
      bus_write(4'h6, 8'hAA);
      check("R2 write to 0x6 ignored", line_drive, 48'h0000_F000_0000);
      bus_write(4'h3, 8'h00);

      // Edge configuration: port 0 bit0 rising, bit1 falling, both enabled;
      // port 2 bit7 rising and enabled
      pad_in = 48'h0;
      settle();
      bus_write(4'h7, 8'h40);
      bus_write(4'h8, 8'h01);
      bus_write(4'hA, 8'h80);
      bus_write(4'h7, 8'h80);
      bus_write(4'h8, 8'h03);
      bus_write(4'hA, 8'h80);
      bus_write(4'h7, 8'hC0);
      check("R8 no irq before edges", {47'h0, irq}, 48'h0);

      pad_in[0] = 1'b1;
      settle();
      check("R6 rising edge on line 0 raises irq (R8)", {47'h0, irq}, 48'h1);
      pad_in[1] = 1'b1;
      settle();
      bus_read(4'h8, rv);
      check("R6 falling-polarity line ignores rise", {40'h0, rv}, 48'h01);
      pad_in[1] = 1'b0;
      settle();
      bus_read(4'h8, rv);
      check("R6 falling edge latched", {40'h0, rv}, 48'h03);
      pad_in[2] = 1'b1; settle();
      pad_in[2] = 1'b0; settle();
      pad_in[47:24] = 24'hFFFFFF; settle();
      pad_in[47:24] = 24'h0; settle();
      bus_read(4'h8, rv);
      check("R6 disabled line stays clear", {40'h0, rv}, 48'h03);
      bus_read(4'h6, rv);
      check("R9 R10 summary only port 0", {40'h0, rv}, 48'h01);

      bus_write(4'h8, 8'h00);
      bus_read(4'h8, rv);
      check("R7 zero write keeps pending", {40'h0, rv}, 48'h03);
      bus_write(4'h8, 8'h01);
      bus_read(4'h8, rv);
      check("R7 one clears bit 0", {40'h0, rv}, 48'h02);
      check("R8 irq still set", {47'h0, irq}, 48'h1);
      bus_write(4'h8, 8'h02);
      check("R8 irq drops when all clear", {47'h0, irq}, 48'h0);

      pad_in[23] = 1'b1;
      settle();
      bus_read(4'hA, rv);
      check("R6 port 2 bit 7 rising", {40'h0, rv}, 48'h80);
      bus_read(4'h6, rv);
      check("R9 summary port 2", {40'h0, rv}, 48'h04);
      bus_write(4'hA, 8'h80);
      check("R8 irq low after ack", {47'h0, irq}, 48'h0);

      // R7 collision: edge and clear on the same clock edge
      pad_in[0] = 1'b0;
      settle();
      pad_in[0] = 1'b1;
      @(negedge clk);
      bus_write(4'h8, 8'h01);
      bus_read(4'h8, rv);
      check("R7 edge beats simultaneous clear", {40'h0, rv}, 48'h01);
      bus_read(4'hB, rv);
      check("R10 unmapped offset reads zero", {40'h0, rv}, 48'h00);

      finish_run();
   end
endmodule